// File: doc/BRIEF.md
# Coherent Byte-Read Timer Counter

This block is a 16-bit up-counter that an 8-bit processor bus sees as two byte locations, a high byte and a low byte. The counter advances by one on every cycle in which its tick enable is high, and it wraps from 0xFFFF to 0x0000. A read of either byte never disturbs the count.

A processor reads the full value high byte first. That read copies the low byte into a one-entry buffer, and a low-byte read in the very next cycle is answered from that buffer. The two bytes therefore form one consistent 16-bit value, even when a carry ripples into the high byte between the two accesses. A low-byte read at any other time returns the live low byte.

Writes do not load the data they carry. In normal mode any write clears the counter. In test mode a write to the high byte presets the counter to 0xFFF8, a few ticks short of rollover, so a test can reach the wrap quickly. A stop input holds the counter at zero for as long as it is high.

Top module: `coherent_byte_timer`

## Requirements
- R1: After reset the count output is 0x0000 and the read data bus is 0x00.
- R2: With tick_en high and stop and wr low, the count rises by one per clock and wraps from 0xFFFF to 0x0000.
- R3: With tick_en, stop and wr all low, the count holds its value.
- R4: With test_mode low, a write to either byte with any data value sets the count to 0x0000 at the next clock edge, even when tick_en is high.
- R5: With test_mode high, a write to the high byte (sel_hi = 1) sets the count to 0xFFF8 at the next clock edge, even when tick_en is high.
- R6: With test_mode high, a write to the low byte (sel_hi = 0) has no effect: the count advances or holds as R2 and R3 give.
- R7: While stop is high, the count becomes 0x0000 at the next clock edge and stays there, whatever wr and tick_en do.
- R8: A read with sel_hi = 1 puts count[15:8] on rdata in the same cycle, and reads never change the count.
- R9: A read with sel_hi = 0 in the cycle right after a read with sel_hi = 1 returns the value count[7:0] had during that high-byte read.
- R10: A read with sel_hi = 0 that does not directly follow a high-byte read returns the live count[7:0].
- R11: rdata is 0x00 in every cycle in which rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable for this cycle |
| stop | input | 1 | Hold the counter at zero |
| test_mode | input | 1 | 0 = normal write clears, 1 = high-byte write presets |
| sel_hi | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data (value is not loaded) |
| rdata | output | 8 | Read data |
| count | output | 16 | Current counter value |

## Verification
Count changes from ticks, writes and stop are due one clock edge after the cycle that carries them, so the bench applies each stimulus after a falling edge, lets the rising edge act, and compares count at the next falling edge. Read data is combinational from the current strobes, so it is compared within the same cycle, a moment after the inputs settle and before the edge. The buffered low byte is due only in the single cycle after a high-byte read, and the bench spaces reads to exercise both that cycle and later ones. A reference model built from integers steps on every edge, and both outputs are compared against it every cycle.

// File: rtl/coherent_byte_timer.sv
module coherent_byte_timer #(
  parameter int          BYTE_W     = 8,
  parameter logic [15:0] TEST_PRESET = 16'hFFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              stop,
  input  logic              test_mode,
  input  logic              sel_hi,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [2*BYTE_W-1:0] count
);
  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_hold;
  logic              hold_vld;
  logic              hi_read;
  logic              do_clear;
  logic              do_preset;

  assign hi_read   = rd && sel_hi;
  assign do_clear  = stop || (wr && !test_mode);
  assign do_preset = wr && test_mode && sel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      lo_hold  <= '0;
      hold_vld <= 1'b0;
    end else begin
      hold_vld <= hi_read;
      if (hi_read) lo_hold <= count[BYTE_W-1:0];
      if (do_clear)       count <= '0;
      else if (do_preset) count <= TEST_PRESET[CW-1:0];
      else if (tick_en)   count <= count + 1'b1;
    end
  end

  assign rdata = !rd      ? '0 :
                 sel_hi   ? count[CW-1:BYTE_W] :
                 hold_vld ? lo_hold : count[BYTE_W-1:0];

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !stop && !wr) |=> count == $past(count) + 1'b1);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !stop && !wr) |=> $stable(count));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !test_mode) |=> count == '0);

  p_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && test_mode && sel_hi && !stop) |=> count == TEST_PRESET[CW-1:0]);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> count == '0);

  p_coherent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel_hi) ##1 (rd && !sel_hi) |-> rdata == $past(count[BYTE_W-1:0]));

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rdata == '0);
endmodule

// File: tb/sim_coherent_byte_timer.sv
module sim_coherent_byte_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 0, stop = 0, test_mode = 0, sel_hi = 0, rd = 0, wr = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [15:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_cnt = 0;
  int m_buf = 0;
  bit m_bv  = 0;

  always #10 clk = ~clk;

  coherent_byte_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stop(stop),
    .test_mode(test_mode), .sel_hi(sel_hi), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .count(count)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (!rd) return 0;
    if (sel_hi) return (m_cnt >> 8) & 255;
    if (m_bv) return m_buf;
    return m_cnt & 255;
  endfunction

  task automatic cyc(string req, bit t, bit s, bit tm, bit hi, bit r, bit w, int d);
    tick_en = t; stop = s; test_mode = tm; sel_hi = hi; rd = r; wr = w; wdata = d[7:0];
    #2;
    check(req, "rdata", int'(rdata), exp_rdata());
    @(posedge clk);
    begin
      bit hr;
      hr = r && hi;
      if (hr) m_buf = m_cnt & 255;
      m_bv = hr;
      if (s || (w && !tm)) m_cnt = 0;
      else if (w && tm && hi) m_cnt = 16'hFFF8;
      else if (t) m_cnt = (m_cnt + 1) & 16'hFFFF;
    end
    @(negedge clk);
    check(req, "count", int'(count), m_cnt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "count", int'(count), 0);
    check("R1", "rdata", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 20; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++)  cyc("R3", 0, 0, 0, 1, 0, 0, 0);
    cyc("R11", 1, 0, 0, 1, 0, 0, 0);

    cyc("R4", 1, 0, 0, 1, 0, 1, 8'h5A);
    for (int i = 0; i < 7; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 0, 0, 1, 8'hFF);
    for (int i = 0; i < 3; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 8'h00);

    cyc("R5", 1, 0, 1, 1, 0, 1, 8'h12);
    for (int i = 0; i < 10; i++) cyc("R2", 1, 0, 1, 0, 0, 0, 0);
    cyc("R6", 1, 0, 1, 0, 0, 1, 8'h34);
    cyc("R6", 0, 0, 1, 0, 0, 1, 8'h34);
    cyc("R5", 0, 0, 1, 1, 0, 1, 8'h00);
    cyc("R3", 0, 0, 1, 0, 0, 0, 0);

    cyc("R7", 1, 1, 1, 1, 0, 1, 8'h77);
    for (int i = 0; i < 4; i++) cyc("R7", 1, 1, 0, 0, 0, i[0], 0);
    for (int i = 0; i < 3; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);

    cyc("R5", 1, 0, 1, 1, 0, 1, 0);
    for (int i = 0; i < 6; i++) begin
      cyc("R8", 1, 0, 0, 1, 1, 0, 0);
      cyc("R9", 1, 0, 0, 0, 1, 0, 0);
    end
    cyc("R8", 0, 0, 0, 1, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 0, 0);
    cyc("R10", 1, 0, 0, 0, 1, 0, 0);
    cyc("R8", 1, 0, 0, 1, 1, 0, 0);
    cyc("R10", 1, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 0, 0, 0, 1, 0, 0);
    cyc("R8", 1, 0, 0, 1, 1, 0, 0);
    cyc("R8", 1, 0, 0, 1, 1, 0, 0);
    cyc("R9", 1, 0, 0, 0, 1, 0, 0);
    cyc("R10", 1, 0, 0, 0, 1, 0, 0);
    cyc("R11", 1, 0, 0, 0, 0, 0, 0);

    finish_run();
  end
endmodule